// File: doc/BRIEF.md
# External Asynchronous Memory Bus Controller

This block turns single-word requests from an on-chip master into access cycles on an external asynchronous memory bus. Each request carries an address, write data, byte enables and a read/write flag. The master holds the request until it sees a one-cycle acknowledge. The controller sorts each address into one of three regions: a boot-PROM window with two chip selects, a set of SRAM banks that each have their own select and output enable, or one memory-mapped I/O window. It then drives the matching strobes from registers.

Each region has its own wait-state count, set on static configuration inputs. The PROM and I/O windows can each be set up as 8-bit areas, which use only the top data lane. Writes to PROM or SRAM can also be marked as error-protected. On those writes a check-bit bus is driven from a separate code input, with one extra top bit that comes from configuration. An I/O access runs through its wait states and then waits for the external bus-ready input to go low.

Top module: `ext_mem_ctrl`

## Requirements
- R1: Region decode uses request address bits 30:29. The value 00 selects the PROM window, 01 selects the I/O window, and 1x selects SRAM. In the PROM window, `rom_cs_n[0]` goes low when address bit 28 is 0, which is an offset below 0x10000000. `rom_cs_n[1]` goes low when bit 28 is 1. In SRAM, address bits 21:20 choose the bank, and only `ram_cs_n` of that bank goes low. `io_cs_n` goes low for the I/O window. At most one select is ever low.
- R2: `mem_addr` shows request address bits 27:0 throughout an access. It keeps that value after the access ends, until the next request is accepted.
- R3: A read drives `oe_n` low and `rd_strobe` high. For an SRAM read, `ram_oe_n` of the selected bank is also driven low. No `ram_oe_n` bit goes low on writes or outside SRAM.
- R4: A write drives `wr_n` low. `mem_doe` is high only during write cycles and stays low during reads.
- R5: In a 32-bit area, byte strobe `bwe_n[i]` is low exactly when `req_be[3-i]` is set. Strobe 0 therefore covers data bits 31:24, and strobe 3 covers bits 7:0. `mem_dout` carries `req_wdata` unchanged.
- R6: In an 8-bit area, let k = 3 - addr[1:0]. A write drives only `bwe_n[0]` low and puts byte k of `req_wdata` on `mem_dout[31:24]`, with the other bits zero. A read returns `mem_din[31:24]` in byte k of `rdata`, with the other bytes zero.
- R7: Let W be the region's wait-state count (0..15), and say the request is accepted at clock edge E0. For PROM and SRAM, the strobes are active for W+1 cycles. The access ends at edge E(W+1), and `ack` is high for the cycle that follows that edge.
- R8: An I/O access ends at the first edge, from E(W+1) onward, at which `brdy_n` is sampled low. If bus-ready is already low during the wait states, the access does not end early. `io_cs_n` returns high only at an edge where `brdy_n` was low.
- R9: `cb_oe` is high only on writes to a protected region. The protected regions are PROM when `prot_prom` is set and SRAM when `prot_sram` is set. I/O is never protected. While driven, `cb_out` equals {`cb_top`, `cb_code`}.
- R10: `ack` is high for exactly one cycle per access. On reads, `rdata` is captured from the data bus at the same edge that raises `ack`.
- R11: After synchronous reset, all selects, strobes and output enables are inactive, `mem_addr` and `rdata` are zero, and `ack` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request valid, held until ack |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 31 | Request byte address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables, bit i covers data bits 8i+7:8i |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Read data, valid with ack |
| ws_prom | input | 4 | PROM wait states |
| ws_sram | input | 4 | SRAM wait states |
| ws_io | input | 4 | I/O wait states |
| narrow_prom | input | 1 | PROM window is 8-bit |
| narrow_io | input | 1 | I/O window is 8-bit |
| prot_prom | input | 1 | PROM writes drive check bits |
| prot_sram | input | 1 | SRAM writes drive check bits |
| cb_top | input | 1 | Value for check-bit 7 |
| cb_code | input | 7 | Code bits for check-bit 6:0 |
| mem_addr | output | 28 | External address bus |
| rom_cs_n | output | 2 | PROM selects, active low |
| ram_cs_n | output | 4 | SRAM bank selects, active low |
| ram_oe_n | output | 4 | SRAM bank output enables, active low |
| io_cs_n | output | 1 | I/O select, active low |
| oe_n | output | 1 | Read output enable, active low |
| rd_strobe | output | 1 | Read cycle, active high |
| wr_n | output | 1 | Write strobe, active low |
| bwe_n | output | 4 | Byte write strobes, bit 0 = data 31:24 |
| mem_dout | output | 32 | Data bus output value |
| mem_doe | output | 1 | Data bus output enable |
| mem_din | input | 32 | Data bus input value |
| cb_out | output | 8 | Check-bit bus output value |
| cb_oe | output | 1 | Check-bit bus output enable |
| brdy_n | input | 1 | I/O bus ready, active low |

## Verification
All bus strobes and selects are registered. They take their access values one edge after the request is accepted, so the bench checks them at the falling edge that follows the acceptance edge. The acknowledge and the read data are due W+1 edges after acceptance, plus any extra cycles an I/O access spends waiting on bus-ready. The driver records the acceptance cycle and pushes that due cycle, together with the expected read data, into a queue. The monitor compares both against the cycle in which `ack` actually appears, and the driver counts strobe-active cycles to confirm the same length.

// File: rtl/memc_pkg.sv
package memc_pkg;
  typedef enum logic [1:0] {
    RG_PROM = 2'd0,
    RG_IO   = 2'd1,
    RG_SRAM = 2'd2
  } region_e;

  typedef enum logic {
    S_IDLE = 1'b0,
    S_BUSY = 1'b1
  } seq_state_e;
endpackage

// File: rtl/memc_decode.sv
module memc_decode
  import memc_pkg::*;
#(
  parameter int NBANK  = 4,
  parameter int BANK_W = 2,
  parameter int WS_W   = 4
) (
  input  logic [1:0]        rgn_bits,
  input  logic              rom_half,
  input  logic [BANK_W-1:0] bank_idx,
  input  logic [WS_W-1:0]   ws_prom,
  input  logic [WS_W-1:0]   ws_sram,
  input  logic [WS_W-1:0]   ws_io,
  input  logic              narrow_prom,
  input  logic              narrow_io,
  input  logic              prot_prom,
  input  logic              prot_sram,
  output region_e           region,
  output logic [1:0]        rom_sel,
  output logic [NBANK-1:0]  bank_sel,
  output logic [WS_W-1:0]   ws,
  output logic              narrow,
  output logic              prot
);
  always_comb begin
    unique case (rgn_bits)
      2'b00:   region = RG_PROM;
      2'b01:   region = RG_IO;
      default: region = RG_SRAM;
    endcase
  end

  // upper/lower half of the boot window
  always_comb begin
    rom_sel = 2'b00;
    if (region == RG_PROM) rom_sel = rom_half ? 2'b10 : 2'b01;
  end

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    assign bank_sel[g] = (region == RG_SRAM) && (bank_idx == BANK_W'(g));
  end

  always_comb begin
    unique case (region)
      RG_PROM: begin ws = ws_prom; narrow = narrow_prom; prot = prot_prom; end
      RG_IO:   begin ws = ws_io;   narrow = narrow_io;   prot = 1'b0;      end
      default: begin ws = ws_sram; narrow = 1'b0;        prot = prot_sram; end
    endcase
  end
endmodule

// File: rtl/memc_lanes.sv
module memc_lanes #(
  parameter int DW = 32,
  localparam int NL = DW / 8,
  localparam int OW = $clog2(NL)
) (
  input  logic [DW-1:0] wdata,
  input  logic [NL-1:0] be,
  input  logic          wr_narrow,
  input  logic [OW-1:0] wr_off,
  input  logic [DW-1:0] bus_in,
  input  logic          rd_narrow,
  input  logic [OW-1:0] rd_off,
  output logic [DW-1:0] bus_wdata,
  output logic [NL-1:0] bwe_act,
  output logic [DW-1:0] rd_fmt
);
  logic [OW-1:0] wk, rk;

  // write side: strobe index 0 belongs to the most significant lane
  always_comb begin
    wk        = OW'(NL - 1) - wr_off;
    bus_wdata = '0;
    bwe_act   = '0;
    if (wr_narrow) begin
      bus_wdata[DW-1 -: 8] = wdata[int'(wk)*8 +: 8];
      bwe_act[0]           = 1'b1;
    end else begin
      bus_wdata = wdata;
      for (int i = 0; i < NL; i++) bwe_act[i] = be[NL-1-i];
    end
  end

  // read side: narrow areas deliver the top lane into the addressed byte
  always_comb begin
    rk     = OW'(NL - 1) - rd_off;
    rd_fmt = '0;
    if (rd_narrow) rd_fmt[int'(rk)*8 +: 8] = bus_in[DW-1 -: 8];
    else           rd_fmt = bus_in;
  end
endmodule

// File: rtl/memc_seq.sv
module memc_seq
  import memc_pkg::*;
#(
  parameter int WS_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req,
  input  logic            is_io,
  input  logic [WS_W-1:0] ws,
  input  logic            brdy_n,
  output logic            start,
  output logic            finish
);
  seq_state_e      st;
  logic [WS_W-1:0] cnt;
  logic            io_q;

  assign start  = (st == S_IDLE) && req;
  assign finish = (st == S_BUSY) && (cnt == '0) && (!io_q || !brdy_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= S_IDLE;
      cnt  <= '0;
      io_q <= 1'b0;
    end else if (start) begin
      st   <= S_BUSY;
      cnt  <= ws;
      io_q <= is_io;
    end else if (finish) begin
      st <= S_IDLE;
    end else if (st == S_BUSY && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/ext_mem_ctrl.sv
module ext_mem_ctrl
  import memc_pkg::*;
#(
  parameter int AW           = 31,
  parameter int BUS_AW       = 28,
  parameter int DW           = 32,
  parameter int NBANK        = 4,
  parameter int BANK_LSB     = 20,
  parameter int WS_W         = 4,
  parameter int CB_W         = 8,
  parameter int ROM_HALF_BIT = 28,
  parameter int RGN_LSB      = 29,
  localparam int NL          = DW / 8,
  localparam int OW          = $clog2(NL),
  localparam int BANK_W      = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_we,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic [NL-1:0]     req_be,
  output logic              ack,
  output logic [DW-1:0]     rdata,
  input  logic [WS_W-1:0]   ws_prom,
  input  logic [WS_W-1:0]   ws_sram,
  input  logic [WS_W-1:0]   ws_io,
  input  logic              narrow_prom,
  input  logic              narrow_io,
  input  logic              prot_prom,
  input  logic              prot_sram,
  input  logic              cb_top,
  input  logic [CB_W-2:0]   cb_code,
  output logic [BUS_AW-1:0] mem_addr,
  output logic [1:0]        rom_cs_n,
  output logic [NBANK-1:0]  ram_cs_n,
  output logic [NBANK-1:0]  ram_oe_n,
  output logic              io_cs_n,
  output logic              oe_n,
  output logic              rd_strobe,
  output logic              wr_n,
  output logic [NL-1:0]     bwe_n,
  output logic [DW-1:0]     mem_dout,
  output logic              mem_doe,
  input  logic [DW-1:0]     mem_din,
  output logic [CB_W-1:0]   cb_out,
  output logic              cb_oe,
  input  logic              brdy_n
);
  region_e           region;
  logic [1:0]        rom_sel;
  logic [NBANK-1:0]  bank_sel;
  logic [WS_W-1:0]   ws;
  logic              narrow, prot;
  logic              start, finish;
  logic [DW-1:0]     bus_wdata, rd_fmt;
  logic [NL-1:0]     bwe_act;
  logic              we_q, narrow_q;
  logic [OW-1:0]     off_q;

  memc_decode #(.NBANK(NBANK), .BANK_W(BANK_W), .WS_W(WS_W)) u_decode (
    .rgn_bits    (req_addr[RGN_LSB +: 2]),
    .rom_half    (req_addr[ROM_HALF_BIT]),
    .bank_idx    (req_addr[BANK_LSB +: BANK_W]),
    .ws_prom     (ws_prom),
    .ws_sram     (ws_sram),
    .ws_io       (ws_io),
    .narrow_prom (narrow_prom),
    .narrow_io   (narrow_io),
    .prot_prom   (prot_prom),
    .prot_sram   (prot_sram),
    .region      (region),
    .rom_sel     (rom_sel),
    .bank_sel    (bank_sel),
    .ws          (ws),
    .narrow      (narrow),
    .prot        (prot)
  );

  memc_seq #(.WS_W(WS_W)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .req    (req),
    .is_io  (region == RG_IO),
    .ws     (ws),
    .brdy_n (brdy_n),
    .start  (start),
    .finish (finish)
  );

  memc_lanes #(.DW(DW)) u_lanes (
    .wdata     (req_wdata),
    .be        (req_be),
    .wr_narrow (narrow),
    .wr_off    (req_addr[OW-1:0]),
    .bus_in    (mem_din),
    .rd_narrow (narrow_q),
    .rd_off    (off_q),
    .bus_wdata (bus_wdata),
    .bwe_act   (bwe_act),
    .rd_fmt    (rd_fmt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr  <= '0;
      rom_cs_n  <= '1;
      ram_cs_n  <= '1;
      ram_oe_n  <= '1;
      io_cs_n   <= 1'b1;
      oe_n      <= 1'b1;
      rd_strobe <= 1'b0;
      wr_n      <= 1'b1;
      bwe_n     <= '1;
      mem_dout  <= '0;
      mem_doe   <= 1'b0;
      cb_out    <= '0;
      cb_oe     <= 1'b0;
      ack       <= 1'b0;
      rdata     <= '0;
      we_q      <= 1'b0;
      narrow_q  <= 1'b0;
      off_q     <= '0;
    end else begin
      ack <= finish;
      if (start) begin
        mem_addr  <= req_addr[BUS_AW-1:0];
        rom_cs_n  <= ~rom_sel;
        ram_cs_n  <= ~bank_sel;
        ram_oe_n  <= req_we ? '1 : ~bank_sel;
        io_cs_n   <= (region != RG_IO);
        oe_n      <= req_we;
        rd_strobe <= !req_we;
        wr_n      <= !req_we;
        bwe_n     <= req_we ? ~bwe_act : '1;
        mem_doe   <= req_we;
        cb_oe     <= req_we && prot;
        if (req_we) mem_dout <= bus_wdata;
        if (req_we && prot) cb_out <= {cb_top, cb_code};
        we_q      <= req_we;
        narrow_q  <= narrow;
        off_q     <= req_addr[OW-1:0];
      end else if (finish) begin
        rom_cs_n  <= '1;
        ram_cs_n  <= '1;
        ram_oe_n  <= '1;
        io_cs_n   <= 1'b1;
        oe_n      <= 1'b1;
        rd_strobe <= 1'b0;
        wr_n      <= 1'b1;
        bwe_n     <= '1;
        mem_doe   <= 1'b0;
        cb_oe     <= 1'b0;
        if (!we_q) rdata <= rd_fmt;
      end
    end
  end
endmodule

// File: rtl/memc_checker.sv
module memc_checker #(
  parameter int NBANK  = 4,
  parameter int BUS_AW = 28
) (
  input logic              clk,
  input logic              rst,
  input logic              ack,
  input logic              oe_n,
  input logic              rd_strobe,
  input logic              wr_n,
  input logic              mem_doe,
  input logic              cb_oe,
  input logic [1:0]        rom_cs_n,
  input logic [NBANK-1:0]  ram_cs_n,
  input logic [NBANK-1:0]  ram_oe_n,
  input logic              io_cs_n,
  input logic [BUS_AW-1:0] mem_addr,
  input logic              brdy_n
);
  logic any_sel;
  assign any_sel = !(&{rom_cs_n, ram_cs_n, io_cs_n});

  assert_one_select_R1: assert property (@(posedge clk) disable iff (rst)
    $countones({~rom_cs_n, ~ram_cs_n, ~io_cs_n}) <= 1);

  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (any_sel && $past(any_sel)) |-> $stable(mem_addr));

  assert_no_drive_on_read_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe || !oe_n) |-> !mem_doe);

  assert_cb_on_write_R9: assert property (@(posedge clk) disable iff (rst)
    cb_oe |-> !wr_n);

  assert_io_end_ready_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(io_cs_n) |-> !$past(brdy_n));

  assert_ack_single_R10: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  for (genvar g = 0; g < NBANK; g++) begin : g_oe
    assert_bank_oe_R3: assert property (@(posedge clk) disable iff (rst)
      !ram_oe_n[g] |-> (!ram_cs_n[g] && rd_strobe));
  end
endmodule

bind ext_mem_ctrl memc_checker #(.NBANK(NBANK), .BUS_AW(BUS_AW)) u_memc_chk (
  .clk       (clk),
  .rst       (rst),
  .ack       (ack),
  .oe_n      (oe_n),
  .rd_strobe (rd_strobe),
  .wr_n      (wr_n),
  .mem_doe   (mem_doe),
  .cb_oe     (cb_oe),
  .rom_cs_n  (rom_cs_n),
  .ram_cs_n  (ram_cs_n),
  .ram_oe_n  (ram_oe_n),
  .io_cs_n   (io_cs_n),
  .mem_addr  (mem_addr),
  .brdy_n    (brdy_n)
);

// File: tb/test_ext_mem_ctrl.sv
module test_ext_mem_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0, req_we = 1'b0;
  logic [30:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_be = '0;
  logic        ack;
  logic [31:0] rdata;
  logic [3:0]  ws_prom = '0, ws_sram = '0, ws_io = '0;
  logic        narrow_prom = 1'b0, narrow_io = 1'b0, prot_prom = 1'b0, prot_sram = 1'b0;
  logic        cb_top = 1'b1;
  logic [6:0]  cb_code = 7'h5A;
  logic [27:0] mem_addr;
  logic [1:0]  rom_cs_n;
  logic [3:0]  ram_cs_n, ram_oe_n, bwe_n;
  logic        io_cs_n, oe_n, rd_strobe, wr_n, mem_doe, cb_oe;
  logic [31:0] mem_dout;
  logic [31:0] mem_din = 32'hC3A5_1E7F;
  logic [7:0]  cb_out;
  logic        brdy_n = 1'b1;

  int nchk = 0, nerr = 0, cyc = 0;
  bit done = 1'b0;

  typedef struct { int due; logic [31:0] data; bit is_rd; } exp_t;
  exp_t sbq[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ext_mem_ctrl i_ext_mem_ctrl (
    .clk(clk), .rst(rst), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .ack(ack), .rdata(rdata),
    .ws_prom(ws_prom), .ws_sram(ws_sram), .ws_io(ws_io),
    .narrow_prom(narrow_prom), .narrow_io(narrow_io),
    .prot_prom(prot_prom), .prot_sram(prot_sram),
    .cb_top(cb_top), .cb_code(cb_code),
    .mem_addr(mem_addr), .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n),
    .ram_oe_n(ram_oe_n), .io_cs_n(io_cs_n), .oe_n(oe_n), .rd_strobe(rd_strobe),
    .wr_n(wr_n), .bwe_n(bwe_n), .mem_dout(mem_dout), .mem_doe(mem_doe),
    .mem_din(mem_din), .cb_out(cb_out), .cb_oe(cb_oe), .brdy_n(brdy_n)
  );

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every acknowledge (R7, R10)
  always @(negedge clk) begin
    if (!rst && ack) begin
      if (sbq.size() == 0) begin
        chk("R10 ack without pending access", 64'd1, 64'd0);
      end else begin
        exp_t it;
        it = sbq.pop_front();
        chk("R7 ack cycle", 64'(cyc), 64'(it.due));
        if (it.is_rd) chk("R10 R6 read data", 64'(rdata), 64'(it.data));
      end
    end
  end

  // driver: one access; d = extra cycles of bus-ready high for I/O
  task automatic access(input logic w, input logic [30:0] a, input logic [3:0] b,
                        input logic [31:0] wd, input int d_in);
    logic [1:0]  rg;
    logic        nar, prt, e_io;
    logic [1:0]  e_rom;
    logic [3:0]  e_ram, e_roe, e_bwe;
    logic [31:0] e_dout, e_rd;
    int W, k, acc, n, kk, d;
    exp_t it;
    rg  = a[30:29];
    d   = (rg == 2'b01) ? d_in : 0;
    W   = (rg == 2'b00) ? int'(ws_prom) : (rg == 2'b01) ? int'(ws_io) : int'(ws_sram);
    nar = (rg == 2'b00 && narrow_prom) || (rg == 2'b01 && narrow_io);
    prt = (rg == 2'b00 && prot_prom) || (rg[1] && prot_sram);
    e_rom = (rg == 2'b00) ? (a[28] ? 2'b01 : 2'b10) : 2'b11;
    e_ram = rg[1] ? ~(4'b0001 << a[21:20]) : 4'hF;
    e_roe = (!w && rg[1]) ? e_ram : 4'hF;
    e_io  = (rg != 2'b01);
    k = 3 - int'(a[1:0]);
    e_bwe  = nar ? 4'b1110 : ~{b[0], b[1], b[2], b[3]};
    e_dout = nar ? {wd[k*8 +: 8], 24'h0} : wd;
    e_rd   = nar ? (32'(mem_din[31:24]) << (8 * k)) : mem_din;

    @(negedge clk);
    req = 1'b1; req_we = w; req_addr = a; req_be = b; req_wdata = wd;
    brdy_n = !(rg == 2'b01 && d == 0);
    @(negedge clk);
    acc = cyc;
    it.due = acc + W + 1 + d; it.data = e_rd; it.is_rd = !w;
    sbq.push_back(it);

    chk("R2 address driven", 64'(mem_addr), 64'(a[27:0]));
    chk("R1 prom selects", 64'(rom_cs_n), 64'(e_rom));
    chk("R1 sram selects", 64'(ram_cs_n), 64'(e_ram));
    chk("R1 io select", 64'(io_cs_n), 64'(e_io));
    chk("R3 bank output enables", 64'(ram_oe_n), 64'(e_roe));
    chk("R4 data drive only on write", 64'(mem_doe), 64'(w));
    if (!w) begin
      chk("R3 oe_n low", 64'(oe_n), 64'd0);
      chk("R3 read high", 64'(rd_strobe), 64'd1);
      chk("R4 no write strobe on read", 64'(wr_n), 64'd1);
    end else begin
      chk("R4 write strobe", 64'(wr_n), 64'd0);
      chk("R3 oe_n high on write", 64'(oe_n), 64'd1);
      chk(nar ? "R6 narrow byte strobes" : "R5 byte strobes", 64'(bwe_n), 64'(e_bwe));
      chk(nar ? "R6 narrow write lane" : "R5 write data", 64'(mem_dout), 64'(e_dout));
    end
    chk("R9 check-bit enable", 64'(cb_oe), 64'(w && prt));
    if (w && prt) chk("R9 check-bit value", 64'(cb_out), 64'({cb_top, cb_code}));

    kk = 0; n = 0;
    while (!ack && kk < 100) begin
      if (rg == 2'b01 && d > 0 && kk == W + d) brdy_n = 1'b0;
      if (!oe_n || !wr_n) n++;
      @(negedge clk);
      kk++;
    end
    chk(rg == 2'b01 ? "R8 io access length" : "R7 strobe length", 64'(n), 64'(W + 1 + d));
    chk("R7 strobes released", 64'({oe_n, wr_n, rom_cs_n, ram_cs_n, io_cs_n, mem_doe}),
        64'({1'b1, 1'b1, 2'b11, 4'hF, 1'b1, 1'b0}));
    chk("R2 address at end", 64'(mem_addr), 64'(a[27:0]));
    req = 1'b0; brdy_n = 1'b1;
    @(negedge clk);
    chk("R10 ack one cycle", 64'(ack), 64'd0);
    chk("R2 idle address held", 64'(mem_addr), 64'(a[27:0]));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 reset selects", 64'({rom_cs_n, ram_cs_n, ram_oe_n, io_cs_n}), 64'({2'b11, 4'hF, 4'hF, 1'b1}));
    chk("R11 reset strobes", 64'({oe_n, rd_strobe, wr_n, bwe_n, mem_doe, cb_oe, ack}),
        64'({1'b1, 1'b0, 1'b1, 4'hF, 1'b0, 1'b0, 1'b0}));
    chk("R11 reset address/data", 64'({mem_addr, rdata}), 64'd0);

    // PROM lower half read, 2 wait states
    ws_prom = 4'd2; prot_prom = 1'b1;
    access(1'b0, 31'h0123_4568, 4'hF, 32'h0, 0);
    // PROM upper half protected write, 0 wait states
    ws_prom = 4'd0;
    access(1'b1, 31'h1000_0040, 4'b1001, 32'hDEAD_BEEF, 0);
    // SRAM bank 2 partial write, protection off then on
    ws_sram = 4'd1;
    access(1'b1, 31'h4020_0010, 4'b0101, 32'h1122_3344, 0);
    prot_sram = 1'b1;
    access(1'b1, 31'h4010_0000, 4'b1110, 32'hA0B1_C2D3, 0);
    // SRAM bank 3 read, long wait
    ws_sram = 4'd15; mem_din = 32'h5566_7788;
    access(1'b0, 31'h6030_0004, 4'hF, 32'h0, 0);
    ws_sram = 4'd0;
    access(1'b0, 31'h4000_0008, 4'hF, 32'h0, 0);
    // I/O narrow read with ready held off, then ready low early
    narrow_io = 1'b1; ws_io = 4'd1; mem_din = 32'h9A00_0000;
    access(1'b0, 31'h2000_0101, 4'h1, 32'h0, 3);
    ws_io = 4'd3;
    access(1'b1, 31'h2000_0202, 4'h4, 32'h7766_5544, 0);
    narrow_io = 1'b0;
    access(1'b1, 31'h2000_0300, 4'hF, 32'h0F1E_2D3C, 2);
    // PROM narrow read and write
    narrow_prom = 1'b1; ws_prom = 4'd1; mem_din = 32'h3C00_FFFF;
    access(1'b0, 31'h0000_0003, 4'h1, 32'h0, 0);
    access(1'b1, 31'h1800_0000, 4'h8, 32'hCAFE_F00D, 0);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nchk++; nerr++;
      $display("FAIL R10 watchdog expired actual=%0d expected=0", cyc);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule